// File: doc/BRIEF.md
# Gap-Synchronised Calibration Trigger Sequencer

This block schedules calibration triggers for three detector calibration systems: charge injection, laser and minimum bias. It runs on the bunch-crossing clock. A host first loads a pattern memory through a synchronous write port. Each turn pulse then reads the next pattern entry, and the entry chooses which calibration, if any, fires in the long empty-bunch gap near the end of the following orbit.

The orbit pulse restarts a clock counter, and the gap opens a fixed number of clocks later. At that moment an armed entry starts its calibration. A minimum-bias request becomes a single trigger. A charge-injection request gives an open pulse and then a close pulse inside the same gap. A laser request fires the laser and then waits for the laser's emission confirmation before it raises the calibration request. Minimum-bias triggers are suppressed for a long dead time after any charge-injection or laser trigger.

Top module: `cal_trig_seq`

## Requirements
- R1: While reset is asserted and on the first clock after it, all trigger outputs and `cal_req_o` are 0, the turn pointer is 0 and no entry is armed.
- R2: Each clock with `turn_i` high reads the pattern entry at the turn pointer, arms it, and advances the pointer by one. The pointer wraps from 2^ADDR_W-1 to 0.
- R3: The gap opens on the clock edge GAP_START clocks after the edge that samples `orbit_i`. An armed entry fires there only if the sequencer is idle, and its first output pulse is high for the one clock after that edge. The entry is consumed, so an orbit without a new turn fires nothing.
- R4: Entry bit 0 requests minimum bias, bit 1 charge injection and bit 2 laser. Laser has priority over charge injection, and charge injection over minimum bias. Bits 7..3 are ignored, and an entry with bits 2..0 all zero fires nothing.
- R5: A charge-injection calibration drives `cis_trig_o` for one clock together with `cal_req_o` = 3'b010. A second one-clock `cis_trig_o` pulse follows exactly CIS_CLOSE_DLY clocks later, still inside the gap.
- R6: A laser calibration drives `laser_trig_o` for one clock and then waits. If `laser_emit_i` is sampled high on one of the next EMIT_TMO edges, `cal_req_o` = 3'b100 for the one clock that follows that edge.
- R7: If no emission confirmation arrives within EMIT_TMO clocks, the laser wait ends with no request, and a later `laser_emit_i` has no effect.
- R8: A minimum-bias calibration drives `mb_trig_o` for one clock together with `cal_req_o` = 3'b001.
- R9: A minimum-bias trigger is dropped if its gap edge comes no more than DEAD_CYC clocks after a charge-injection or laser firing edge. Charge-injection and laser triggers are not affected by this dead time.
- R10: A write on the host port (`wr_en_i`, `wr_addr_i`, `wr_data_i`) stores the byte at that address, and later turn reads return it.
- R11: `laser_emit_i` outside a laser wait produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| orbit_i | input | 1 | Orbit start pulse |
| turn_i | input | 1 | Turn pulse; arms the next pattern entry |
| laser_emit_i | input | 1 | Emission confirmation from the laser |
| wr_en_i | input | 1 | Host pattern write strobe |
| wr_addr_i | input | ADDR_W (12) | Host pattern write address |
| wr_data_i | input | DATA_W (8) | Host pattern write data |
| mb_trig_o | output | 1 | Minimum-bias trigger pulse |
| cis_trig_o | output | 1 | Charge-injection open/close pulses |
| laser_trig_o | output | 1 | Laser fire pulse |
| cal_req_o | output | 3 | One-hot calibration request: bit 0 MB, bit 1 CIS, bit 2 laser |

## Verification
The bench builds the block with ADDR_W=4, GAP_START=40, GAP_LEN=16, CIS_CLOSE_DLY=5, DEAD_CYC=300 and EMIT_TMO=20, and drives an orbit every 64 clocks. At these values the pointer wraps after sixteen turns, so wrap-around and a host rewrite of entry 0 can be checked in a short run. The dead time covers about five orbits, so one minimum-bias entry falls inside it and a later one falls outside it. An emission confirmation 23 clocks after the laser trigger also exercises the laser timeout.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CIS_CLOSE,
    ST_LAS_WAIT
  } seq_state_e;

  localparam logic [2:0] REQ_MB  = 3'b001;
  localparam logic [2:0] REQ_CIS = 3'b010;
  localparam logic [2:0] REQ_LAS = 3'b100;

  localparam int SEL_MB  = 0;
  localparam int SEL_CIS = 1;
  localparam int SEL_LAS = 2;

endpackage

// File: rtl/cal_pattern_mem.sv
module cal_pattern_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // read returns pre-write data on a same-address collision
  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end

endmodule

// File: rtl/cal_gap_timer.sv
module cal_gap_timer #(
  parameter int GAP_START = 3437,
  parameter int GAP_LEN   = 127
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic orbit_i,
  output logic gap_open_o,
  output logic in_gap_o
);
  localparam int LIMIT = GAP_START + GAP_LEN;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (orbit_i) begin
      cnt_q  <= CW'(1);
      seen_q <= 1'b1;
    end else if (seen_q && cnt_q != CW'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gap_open_o = seen_q && (cnt_q == CW'(GAP_START));
  assign in_gap_o   = seen_q && (cnt_q >= CW'(GAP_START)) && (cnt_q < CW'(LIMIT));

  // R3
  orbit_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orbit_i |=> !gap_open_o);

endmodule

// File: rtl/cal_dead_timer.sv
module cal_dead_timer #(
  parameter int DEAD_CYC = 2004000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic dead_o
);
  localparam int DW = $clog2(DEAD_CYC + 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= DW'(DEAD_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign dead_o = (cnt_q != '0);

  // R9
  dead_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> dead_o);

endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
  import cal_pkg::*;
#(
  parameter int CIS_CLOSE_DLY = 40,
  parameter int EMIT_TMO      = 4000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gap_open_i,
  input  logic       armed_i,
  input  logic [2:0] sel_i,
  input  logic       dead_i,
  input  logic       emit_i,
  output logic       fire_o,
  output logic       dead_load_o,
  output logic       mb_trig_o,
  output logic       cis_trig_o,
  output logic       laser_trig_o,
  output logic [2:0] cal_req_o
);
  localparam int MAXC = (CIS_CLOSE_DLY > EMIT_TMO) ? CIS_CLOSE_DLY : EMIT_TMO;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign fire_o      = gap_open_i && armed_i && (state_q == ST_IDLE);
  assign dead_load_o = fire_o && (sel_i[SEL_LAS] || sel_i[SEL_CIS]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      mb_trig_o    <= 1'b0;
      cis_trig_o   <= 1'b0;
      laser_trig_o <= 1'b0;
      cal_req_o    <= '0;
    end else begin
      mb_trig_o    <= 1'b0;
      cis_trig_o   <= 1'b0;
      laser_trig_o <= 1'b0;
      cal_req_o    <= '0;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (fire_o) begin
            if (sel_i[SEL_LAS]) begin
              laser_trig_o <= 1'b1;
              state_q      <= ST_LAS_WAIT;
            end else if (sel_i[SEL_CIS]) begin
              cis_trig_o <= 1'b1;
              cal_req_o  <= REQ_CIS;
              state_q    <= ST_CIS_CLOSE;
            end else if (sel_i[SEL_MB] && !dead_i) begin
              mb_trig_o <= 1'b1;
              cal_req_o <= REQ_MB;
            end
          end
        end
        ST_CIS_CLOSE: begin
          if (cnt_q == CW'(CIS_CLOSE_DLY - 1)) begin
            cis_trig_o <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LAS_WAIT: begin
          if (emit_i) begin
            cal_req_o <= REQ_LAS;
            state_q   <= ST_IDLE;
          end else if (cnt_q == CW'(EMIT_TMO - 1)) begin
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  trig_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mb_trig_o, cis_trig_o, laser_trig_o}) && $onehot0(cal_req_o));

  // R3
  first_pulse_at_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_trig_o || laser_trig_o) |-> $past(gap_open_i));

  // R9
  mb_outside_dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_trig_o |-> !$past(dead_i));

  // R6
  laser_req_after_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_req_o == REQ_LAS) |-> $past(emit_i));

endmodule

// File: rtl/cal_trig_seq.sv
module cal_trig_seq #(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 8,
  parameter int GAP_START     = 3437,
  parameter int GAP_LEN       = 127,
  parameter int CIS_CLOSE_DLY = 40,
  parameter int DEAD_CYC      = 2004000,
  parameter int EMIT_TMO      = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              orbit_i,
  input  logic              turn_i,
  input  logic              laser_emit_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              mb_trig_o,
  output logic              cis_trig_o,
  output logic              laser_trig_o,
  output logic [2:0]        cal_req_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic              armed_q;
  logic [DATA_W-1:0] entry;
  logic              gap_open, in_gap, fire, dead_load, dead;
  logic              unused_entry_hi;

  cal_pattern_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (turn_i),
    .rd_addr_i (ptr_q),
    .rd_data_o (entry)
  );

  assign unused_entry_hi = ^entry[DATA_W-1:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (turn_i) ptr_q <= ptr_q + 1'b1;
      if (turn_i)    armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
    end
  end

  cal_gap_timer #(.GAP_START(GAP_START), .GAP_LEN(GAP_LEN)) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .orbit_i    (orbit_i),
    .gap_open_o (gap_open),
    .in_gap_o   (in_gap)
  );

  cal_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dead_load),
    .dead_o (dead)
  );

  cal_seq_fsm #(.CIS_CLOSE_DLY(CIS_CLOSE_DLY), .EMIT_TMO(EMIT_TMO)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gap_open_i   (gap_open),
    .armed_i      (armed_q),
    .sel_i        (entry[2:0]),
    .dead_i       (dead),
    .emit_i       (laser_emit_i),
    .fire_o       (fire),
    .dead_load_o  (dead_load),
    .mb_trig_o    (mb_trig_o),
    .cis_trig_o   (cis_trig_o),
    .laser_trig_o (laser_trig_o),
    .cal_req_o    (cal_req_o)
  );

  // R2
  ptr_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_i |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));

  // R5
  cis_in_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cis_trig_o |-> $past(in_gap));

  // R3
  fire_consumes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !turn_i) |=> !armed_q);

endmodule

// File: tb/tb_cal_trig_seq.sv
module tb_cal_trig_seq;
  localparam int CLK_P  = 24;
  localparam int AW     = 4;
  localparam int DEPTH  = 1 << AW;
  localparam int GS     = 40;
  localparam int GL     = 16;
  localparam int CD     = 5;
  localparam int DEAD   = 300;
  localparam int TMO    = 20;
  localparam int ORB    = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic orbit = 0, turn = 0, emit = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic mb, cis, las;
  logic [2:0] req;

  int total = 0, bad = 0;
  string tag = "R1";

  cal_trig_seq #(.ADDR_W(AW), .DATA_W(8), .GAP_START(GS), .GAP_LEN(GL),
                 .CIS_CLOSE_DLY(CD), .DEAD_CYC(DEAD), .EMIT_TMO(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .orbit_i(orbit), .turn_i(turn),
    .laser_emit_i(emit), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .mb_trig_o(mb), .cis_trig_o(cis), .laser_trig_o(las), .cal_req_o(req));

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  int cyc = 0;
  logic [7:0] mem_m [DEPTH];
  int ptr_m = 0;
  bit armed_m = 0;
  logic [7:0] ent_m = '0;
  bit have_orb = 0;  int orb_edge = 0;
  bit cis_busy = 0;  int cis_end = 0;
  bit las_wait = 0;  int las_until = 0;
  bit have_dead = 0; int dead_edge = 0;
  bit e_mb[int];
  bit e_cis[int];
  bit e_las[int];
  logic [2:0] e_req[int];
  int n_mb = 0, n_cis = 0, n_las = 0, n_req = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit busy;
      cyc++;
      busy = las_wait || (cis_busy && cyc <= cis_end);
      if (las_wait) begin
        if (emit) begin e_req[cyc] = 3'b100; las_wait = 0; end
        else if (cyc == las_until) las_wait = 0;
      end
      if (have_orb && (cyc - orb_edge == GS) && armed_m && !busy) begin
        armed_m = 0;
        if (ent_m[2]) begin
          e_las[cyc] = 1; las_wait = 1; las_until = cyc + TMO;
          have_dead = 1; dead_edge = cyc;
        end else if (ent_m[1]) begin
          e_cis[cyc] = 1; e_cis[cyc+CD] = 1; e_req[cyc] = 3'b010;
          cis_busy = 1; cis_end = cyc + CD; have_dead = 1; dead_edge = cyc;
        end else if (ent_m[0] && !(have_dead && cyc <= dead_edge + DEAD)) begin
          e_mb[cyc] = 1; e_req[cyc] = 3'b001;
        end
      end
      if (turn) begin armed_m = 1; ent_m = mem_m[ptr_m]; ptr_m = (ptr_m + 1) % DEPTH; end
      if (orbit) begin have_orb = 1; orb_edge = cyc; end
      if (wr_en) mem_m[wr_addr] = wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cyc > 0) begin
      bit xm, xc, xl; logic [2:0] xr;
      xm = e_mb.exists(cyc)  ? e_mb[cyc]  : 1'b0;
      xc = e_cis.exists(cyc) ? e_cis[cyc] : 1'b0;
      xl = e_las.exists(cyc) ? e_las[cyc] : 1'b0;
      xr = e_req.exists(cyc) ? e_req[cyc] : 3'b000;
      total++;
      if (mb !== xm || cis !== xc || las !== xl || req !== xr) begin
        bad++;
        $display("FAIL %s cyc=%0d got mb/cis/las/req=%b%b%b/%b exp=%b%b%b/%b",
                 tag, cyc, mb, cis, las, req, xm, xc, xl, xr);
      end
      n_mb += int'(mb); n_cis += int'(cis); n_las += int'(las); n_req += int'(req != 0);
    end
  end

  task automatic check(string r, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", r, what, act, exp);
    end
  endtask

  task automatic host_write(int a, logic [7:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  // one orbit; emit_at<0 means no emission pulse
  task automatic run_orbit(bit t, int emit_at, int xm, int xc, int xl, int xr, string r);
    int m0 = n_mb, c0 = n_cis, l0 = n_las, q0 = n_req;
    tag = r;
    for (int i = 0; i < ORB; i++) begin
      orbit = (i == 0); turn = t && (i == 5); emit = (i == emit_at);
      @(negedge clk); #1;
    end
    orbit = 0; turn = 0; emit = 0;
    check(r, "mb pulses",    n_mb - m0,  xm);
    check(r, "cis pulses",   n_cis - c0, xc);
    check(r, "laser pulses", n_las - l0, xl);
    check(r, "req pulses",   n_req - q0, xr);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", {mb, cis, las, req}, 0);
    rst_n = 1; #1;
    @(negedge clk); #1;
    check("R1", "outputs after reset", {mb, cis, las, req}, 0);
    // R10 pattern load
    tag = "R10";
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] d;
      case (a)
        0: d = 8'h01; 1: d = 8'h02; 2: d = 8'h01; 6: d = 8'h01;
        7: d = 8'h04; 8: d = 8'hF8; 12: d = 8'h07; 13: d = 8'h03;
        default: d = 8'h00;
      endcase
      host_write(a, d);
    end
    run_orbit(1, -1, 1, 0, 0, 1, "R8");   // MB
    run_orbit(1, -1, 0, 2, 0, 1, "R5");   // CIS open/close
    run_orbit(0, -1, 0, 0, 0, 0, "R3");   // consumed entry, no turn
    run_orbit(1, -1, 0, 0, 0, 0, "R9");   // MB inside dead time dropped
    run_orbit(1, -1, 0, 0, 0, 0, "R4");   // empty entry
    run_orbit(1, 45, 0, 0, 0, 0, "R11");  // stray emit
    run_orbit(1, -1, 0, 0, 0, 0, "R4");
    run_orbit(1, -1, 1, 0, 0, 1, "R9");   // MB after dead time
    run_orbit(1, GS + 3, 0, 0, 1, 1, "R6");
    run_orbit(1, -1, 0, 0, 0, 0, "R4");   // upper bits only
    run_orbit(1, -1, 0, 0, 0, 0, "R4");
    run_orbit(1, -1, 0, 0, 0, 0, "R4");
    run_orbit(1, -1, 0, 0, 0, 0, "R4");
    run_orbit(1, GS + 23, 0, 0, 1, 0, "R7"); // laser priority, late emit
    run_orbit(1, -1, 0, 2, 0, 1, "R4");   // CIS over MB
    run_orbit(1, -1, 0, 0, 0, 0, "R4");
    run_orbit(1, -1, 0, 0, 0, 0, "R4");
    host_write(0, 8'h02);
    run_orbit(1, -1, 0, 2, 0, 1, "R2");   // wrapped to rewritten entry 0
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule